// File: doc/BRIEF.md
# Arithmetic Unit with Status-Flag Word

This block combines a combinational arithmetic/logic datapath with a registered 16-bit status word. Each cycle it takes two operands of parameterised width (8 bits or more) and a 3-bit operation code. It presents the result at once, and it raises a separate write strobe when the result should be stored. When the operation is marked valid, the arithmetic flags in the status word are updated on the next rising clock edge. Flags sit at fixed bit positions, so neighbouring logic can decode them directly.

Dedicated strobes set or clear the interrupt-enable and string-direction flags. A whole-word load port replaces the status word in one cycle, for example when saved flags are restored. That load port is the only way to change the single-step (trap) flag. Compare works like subtract on the flags, but its write strobe stays low, so no result is stored.

Top module: `alu_status_unit`

## Requirements
- R1: Operation codes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare, 5 AND, 6 OR, 7 XOR. `result` is combinational and taken modulo 2^WIDTH. Add-with-carry adds the current bit-0 flag. Subtract-with-borrow also subtracts it.
- R2: Bit 0 (carry) is set after an add that carries out of the top bit, or after a subtract or compare that borrows into it.
- R3: Bit 2 (parity) is set when bits 7..0 of the result hold an even number of ones, whatever the width.
- R4: Bit 4 (nibble adjust) is set on a carry out of result bit 3 in an add, or on a borrow into bit 3 in a subtract or compare, counting the carry/borrow input.
- R5: Bit 6 (zero) is set exactly when the result is all zeros. Bit 7 (sign) equals the result's top bit.
- R6: Bit 11 (overflow) is set on two's-complement signed overflow of an add or subtract.
- R7: Compare updates the arithmetic flags as subtract does, with `result_wr` low. Every other operation drives `result_wr` high when `op_valid` is high.
- R8: AND, OR and XOR clear bits 0 and 11, update bits 2, 6 and 7 from the result, and leave bit 4 unchanged.
- R9: The interrupt-enable flag is bit 9 and the direction flag is bit 10. A set strobe makes its bit 1 and a clear strobe makes it 0 on the next edge; set wins if both are high. With no strobe, no load and `op_valid` low, the status word does not change.
- R10: A load writes the given word, masked to the writable bits 0, 2, 4, 6, 7, 8, 9, 10 and 11, on the next edge. It takes priority over any operation or strobe in the same cycle. Bit 8 (trap) changes only through a load.
- R11: Reset is synchronous and active high and sets the word to 0x0002. Bit 1 always reads 1, and bits 3, 5, 12..15 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present; its flags update on the next edge |
| op_code | input | 3 | Operation select (see R1) |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| result | output | WIDTH | Combinational result |
| result_wr | output | 1 | Result should be written back |
| irq_en_set | input | 1 | Set interrupt-enable flag |
| irq_en_clr | input | 1 | Clear interrupt-enable flag |
| dir_set | input | 1 | Set direction flag |
| dir_clr | input | 1 | Clear direction flag |
| flags_load | input | 1 | Load the whole status word |
| flags_load_data | input | 16 | Word to load |
| flags | output | 16 | Registered status word |

## Verification
A wrong stored carry shows up in the same cycle on `result` when the next operation is add-with-carry or subtract-with-borrow. It shows up one edge later in every arithmetic flag that depends on it. A flag computed wrongly appears on `flags` one edge after the valid operation, and the bench samples there. A lost trap, interrupt-enable or direction bit is therefore found at the first read after the control event. Operand sweeps across all eight operations let the carry chain feed itself, so the carry-in paths are exercised with both values.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_CMP = 3'd4,
        OP_AND = 3'd5,
        OP_OR  = 3'd6,
        OP_XOR = 3'd7
    } alu_op_e;

    localparam int STATUS_W = 16;

    localparam int BIT_CARRY  = 0;
    localparam int BIT_ONE    = 1;
    localparam int BIT_PARITY = 2;
    localparam int BIT_NIBBLE = 4;
    localparam int BIT_ZERO   = 6;
    localparam int BIT_SIGN   = 7;
    localparam int BIT_TRAP   = 8;
    localparam int BIT_IRQEN  = 9;
    localparam int BIT_DIR    = 10;
    localparam int BIT_OVF    = 11;

    localparam logic [STATUS_W-1:0] FIXED_ONES = STATUS_W'(1) << BIT_ONE;
    localparam logic [STATUS_W-1:0] WRITABLE =
        (STATUS_W'(1) << BIT_CARRY)  | (STATUS_W'(1) << BIT_PARITY) |
        (STATUS_W'(1) << BIT_NIBBLE) | (STATUS_W'(1) << BIT_ZERO)   |
        (STATUS_W'(1) << BIT_SIGN)   | (STATUS_W'(1) << BIT_TRAP)   |
        (STATUS_W'(1) << BIT_IRQEN)  | (STATUS_W'(1) << BIT_DIR)    |
        (STATUS_W'(1) << BIT_OVF);

    // Flag candidates produced by the datapath for one operation
    typedef struct packed {
        logic carry;
        logic parity;
        logic nibble;
        logic nibble_upd;
        logic zero;
        logic sign;
        logic ovf;
    } arith_flags_t;

    function automatic logic even_ones(input logic [7:0] byte_in);
        return ~(^byte_in);
    endfunction

    function automatic logic is_logic_op(input alu_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction

endpackage

// File: rtl/alu_core.sv
module alu_core
    import alu_flags_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e           op,
    input  logic [WIDTH-1:0]  a,
    input  logic [WIDTH-1:0]  b,
    input  logic              carry_in,
    output logic [WIDTH-1:0]  res,
    output logic              write_res,
    output arith_flags_t      flg
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] wide;
    logic [4:0]     nib;
    logic           cin;
    logic           subtracting;
    logic           arith;

    always_comb begin
        cin         = ((op == OP_ADC) || (op == OP_SBB)) ? carry_in : 1'b0;
        subtracting = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
        arith       = !is_logic_op(op);
        wide        = '0;
        nib         = '0;
        unique case (op)
            OP_ADD, OP_ADC: begin
                wide = {1'b0, a} + {1'b0, b} + (WIDTH+1)'(cin);
                nib  = {1'b0, a[3:0]} + {1'b0, b[3:0]} + 5'(cin);
            end
            OP_SUB, OP_SBB, OP_CMP: begin
                wide = {1'b0, a} - {1'b0, b} - (WIDTH+1)'(cin);
                nib  = {1'b0, a[3:0]} - {1'b0, b[3:0]} - 5'(cin);
            end
            OP_AND: wide = {1'b0, a & b};
            OP_OR:  wide = {1'b0, a | b};
            OP_XOR: wide = {1'b0, a ^ b};
            default: wide = '0;
        endcase
        res = wide[MSB:0];

        flg.carry      = arith ? wide[WIDTH] : 1'b0;
        flg.nibble     = nib[4];
        flg.nibble_upd = arith;
        flg.parity     = even_ones(res[7:0]);
        flg.zero       = (res == '0);
        flg.sign       = res[MSB];
        if (!arith)
            flg.ovf = 1'b0;
        else if (subtracting)
            flg.ovf = (a[MSB] != b[MSB]) && (res[MSB] != a[MSB]);
        else
            flg.ovf = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);

        write_res = (op != OP_CMP);
    end
endmodule

// File: rtl/status_word_reg.sv
module status_word_reg
    import alu_flags_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                upd_en,
    input  arith_flags_t        upd,
    input  logic                ie_set,
    input  logic                ie_clr,
    input  logic                df_set,
    input  logic                df_clr,
    input  logic                word_we,
    input  logic [STATUS_W-1:0] word_in,
    output logic [STATUS_W-1:0] word_q
);
    logic [STATUS_W-1:0] word_d;

    always_comb begin
        word_d = word_q;
        if (word_we) begin
            word_d = (word_in & WRITABLE) | FIXED_ONES;
        end else begin
            if (upd_en) begin
                word_d[BIT_CARRY]  = upd.carry;
                word_d[BIT_PARITY] = upd.parity;
                word_d[BIT_ZERO]   = upd.zero;
                word_d[BIT_SIGN]   = upd.sign;
                word_d[BIT_OVF]    = upd.ovf;
                if (upd.nibble_upd)
                    word_d[BIT_NIBBLE] = upd.nibble;
            end
            if (ie_set)      word_d[BIT_IRQEN] = 1'b1;
            else if (ie_clr) word_d[BIT_IRQEN] = 1'b0;
            if (df_set)      word_d[BIT_DIR]   = 1'b1;
            else if (df_clr) word_d[BIT_DIR]   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) word_q <= FIXED_ONES;
        else     word_q <= word_d;
    end

    // R11: fixed bits never deviate
    assert_fixed_bits_R11: assert property (@(posedge clk) disable iff (rst)
        (word_q & ~WRITABLE) == FIXED_ONES);

    // R10: trap bit moves only on a whole-word load
    assert_trap_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !word_we |=> $stable(word_q[BIT_TRAP]));

    // R9: set strobe lands, and wins over clear
    assert_irq_set_R9: assert property (@(posedge clk) disable iff (rst)
        (ie_set && !word_we) |=> word_q[BIT_IRQEN]);

    assert_dir_clr_R9: assert property (@(posedge clk) disable iff (rst)
        (df_clr && !df_set && !word_we) |=> !word_q[BIT_DIR]);

    // R9: nothing requested, nothing changes
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!upd_en && !word_we && !ie_set && !ie_clr && !df_set && !df_clr)
        |=> $stable(word_q));
endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
    import alu_flags_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic [2:0]          op_code,
    input  logic [WIDTH-1:0]    opnd_a,
    input  logic [WIDTH-1:0]    opnd_b,
    output logic [WIDTH-1:0]    result,
    output logic                result_wr,
    input  logic                irq_en_set,
    input  logic                irq_en_clr,
    input  logic                dir_set,
    input  logic                dir_clr,
    input  logic                flags_load,
    input  logic [STATUS_W-1:0] flags_load_data,
    output logic [STATUS_W-1:0] flags
);
    alu_op_e      op;
    arith_flags_t cand;
    logic         core_wr;

    assign op = alu_op_e'(op_code);

    alu_core #(.WIDTH(WIDTH)) u_core (
        .op        (op),
        .a         (opnd_a),
        .b         (opnd_b),
        .carry_in  (flags[BIT_CARRY]),
        .res       (result),
        .write_res (core_wr),
        .flg       (cand)
    );

    assign result_wr = op_valid && core_wr;

    status_word_reg u_status (
        .clk     (clk),
        .rst     (rst),
        .upd_en  (op_valid),
        .upd     (cand),
        .ie_set  (irq_en_set),
        .ie_clr  (irq_en_clr),
        .df_set  (dir_set),
        .df_clr  (dir_clr),
        .word_we (flags_load),
        .word_in (flags_load_data),
        .word_q  (flags)
    );

    // R7: compare never requests a write-back
    assert_cmp_no_write_R7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_CMP) |-> !result_wr);

    // R8: logic operations leave carry and overflow clear
    assert_logic_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && is_logic_op(op) && !flags_load)
        |=> (!flags[BIT_CARRY] && !flags[BIT_OVF]));

    // R8: logic operations keep the nibble flag
    assert_logic_keeps_nibble_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && is_logic_op(op) && !flags_load)
        |=> $stable(flags[BIT_NIBBLE]));
endmodule

// File: tb/tb_alu_status_unit.sv
`timescale 1ns/1ps
module tb_alu_status_unit;
    localparam int W = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [2:0]  op_code;
    logic [W-1:0] opnd_a, opnd_b, result;
    logic        result_wr;
    logic        irq_en_set, irq_en_clr, dir_set, dir_clr;
    logic        flags_load;
    logic [15:0] flags_load_data, flags;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;
    logic [15:0] exp_f;

    always #2.5 clk = ~clk;

    alu_status_unit #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .result_wr(result_wr),
        .irq_en_set(irq_en_set), .irq_en_clr(irq_en_clr),
        .dir_set(dir_set), .dir_clr(dir_clr),
        .flags_load(flags_load), .flags_load_data(flags_load_data), .flags(flags)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_res(input logic [2:0] op, input int a, input int b,
                                         input logic c);
        int s;
        case (op)
            3'd0: s = a + b;
            3'd1: s = a + b + int'(c);
            3'd2, 3'd4: s = a - b;
            3'd3: s = a - b - int'(c);
            3'd5: s = a & b;
            3'd6: s = a | b;
            default: s = a ^ b;
        endcase
        return 8'(s & 255);
    endfunction

    function automatic logic [15:0] m_flags(input logic [2:0] op, input int a, input int b,
                                            input logic [15:0] f);
        logic [15:0] n = f;
        int c = ((op == 3'd1) || (op == 3'd3)) ? int'(f[0]) : 0;
        int r = int'(m_res(op, a, b, f[0]));
        if (op <= 3'd1) begin
            n[0]  = (a + b + c) > 255;
            n[4]  = ((a & 15) + (b & 15) + c) > 15;
            n[11] = ((a ^ r) & (b ^ r) & 128) != 0;
        end else if (op <= 3'd4) begin
            n[0]  = (a - b - c) < 0;
            n[4]  = ((a & 15) - (b & 15) - c) < 0;
            n[11] = ((a ^ b) & (a ^ r) & 128) != 0;
        end else begin
            n[0]  = 1'b0;
            n[11] = 1'b0;
        end
        n[2] = ($countones(8'(r)) % 2) == 0;
        n[6] = (r == 0);
        n[7] = (r & 128) != 0;
        return n;
    endfunction

    task automatic cyc(input logic v, input logic [2:0] op, input int a, input int b,
                       input logic is, input logic ic, input logic ds, input logic dc,
                       input logic ld, input logic [15:0] ldd, input string tag);
        logic [15:0] pre;
        @(negedge clk);
        op_valid = v; op_code = op; opnd_a = 8'(a); opnd_b = 8'(b);
        irq_en_set = is; irq_en_clr = ic; dir_set = ds; dir_clr = dc;
        flags_load = ld; flags_load_data = ldd;
        #1;
        pre = exp_f;
        if (v) begin
            chk("R1 result", 32'(result), 32'(m_res(op, a, b, pre[0])));
            chk("R7 result_wr", 32'(result_wr), 32'(op != 3'd4));
        end
        if (ld) exp_f = (ldd & 16'h0FD5) | 16'h0002;
        else begin
            if (v) exp_f = m_flags(op, a, b, pre);
            if (is) exp_f[9] = 1'b1; else if (ic) exp_f[9] = 1'b0;
            if (ds) exp_f[10] = 1'b1; else if (dc) exp_f[10] = 1'b0;
        end
        @(posedge clk);
        #1;
        if (v && !ld) begin
            chk("R2 carry",  32'(flags[0]),  32'(exp_f[0]));
            chk("R3 parity", 32'(flags[2]),  32'(exp_f[2]));
            chk("R4 adjust", 32'(flags[4]),  32'(exp_f[4]));
            chk("R5 zero",   32'(flags[6]),  32'(exp_f[6]));
            chk("R5 sign",   32'(flags[7]),  32'(exp_f[7]));
            chk("R6 ovf",    32'(flags[11]), 32'(exp_f[11]));
        end
        chk(tag, 32'(flags), 32'(exp_f));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual running expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; op_valid = 0; op_code = 0; opnd_a = 0; opnd_b = 0;
        irq_en_set = 0; irq_en_clr = 0; dir_set = 0; dir_clr = 0;
        flags_load = 0; flags_load_data = 16'h0;
        repeat (3) @(posedge clk);
        #1 chk("R11 reset word", 32'(flags), 32'h0002);
        @(negedge clk); rst = 1'b0;
        exp_f = 16'h0002;

        // Operand sweep across every operation (R1..R8)
        for (int op = 0; op < 8; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int j = 0; j < 32; j++) begin
                    int b = ((j % 16) * 17) ^ ((j >= 16) ? 128 : 0);
                    cyc(1'b1, 3'(op), a, b, 0, 0, 0, 0, 0, 16'h0,
                        (op == 4) ? "R7 cmp word" : (op >= 5) ? "R8 logic word" : "R1 word");
                end
            end
        end

        // Loads, masks and priority (R10, R11)
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 16'hFFFF, "R10 load all ones");
        chk("R11 masked value", 32'(flags), 32'h0FD7);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0000, "R11 load zero keeps bit1");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0100, "R10 trap via load");
        chk("R10 trap set", 32'(flags), 32'h0102);
        // Trap survives operations and strobes
        cyc(1, 3'd0, 255, 1, 0, 0, 0, 0, 0, 16'h0, "R10 trap held add");
        cyc(1, 3'd5, 255, 255, 0, 0, 0, 0, 0, 16'h0, "R8 nibble kept after add");
        chk("R10 trap still set", 32'(flags[8]), 32'h1);

        // Interrupt-enable and direction strobes (R9)
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 16'h0, "R9 irq set");
        chk("R9 irq bit9", 32'(flags[9]), 32'h1);
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 16'h0, "R9 irq clear");
        cyc(0, 0, 0, 0, 1, 1, 0, 0, 0, 16'h0, "R9 set wins irq");
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 16'h0, "R9 dir set");
        chk("R9 dir bit10", 32'(flags[10]), 32'h1);
        cyc(0, 0, 0, 0, 0, 0, 1, 1, 0, 16'h0, "R9 set wins dir");
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 16'h0, "R9 dir clear");
        cyc(1, 3'd2, 0, 1, 0, 0, 1, 0, 0, 16'h0, "R9 strobe with op");
        cyc(0, 3'd0, 255, 255, 0, 0, 0, 0, 0, 16'h0, "R9 idle hold");
        cyc(0, 3'd1, 1, 2, 0, 0, 0, 0, 0, 16'h0, "R9 idle hold 2");

        // Load wins over op and strobes (R10)
        cyc(1, 3'd0, 255, 1, 1, 0, 1, 0, 1, 16'h0800, "R10 load priority");
        chk("R10 load value", 32'(flags), 32'h0802);

        // Reset mid-run (R11)
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        chk("R11 reset mid-run", 32'(flags), 32'h0002);
        @(negedge clk); rst = 1'b0;
        exp_f = 16'h0002;
        cyc(1, 3'd4, 5, 5, 0, 0, 0, 0, 0, 16'h0, "R7 cmp equal after reset");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule